// File: doc/BRIEF.md
# Privilege Violation Exception Sequencer

This block carries out exception entry when an instruction running in user mode attempts an operation that only supervisor code may perform. One cycle of the violation strobe hands it four values: the address of the first word of the offending instruction, the live status register, the supervisor stack pointer and the vector base. The block keeps its own untouched copy of the status register. It then publishes a modified status register with the supervisor bit set and both trace-control bits cleared.

Next it writes a four-word frame onto the supervisor stack, one 16-bit word at a time, with a request/acknowledge handshake. The stack pointer is pre-decremented before each word. After the frame it reads the vector entry for vector number 8 from the vector table. It then reports the fetched handler address as the place where execution resumes. Strobes that arrive while a sequence is in flight are dropped.

Top module: `priv_trap_seq`

## Requirements
- R1: After reset, busy_o, wr_req_o, rd_req_o, resume_valid_o and sr_wr_o are all low.
- R2: In the cycle after an accepted strobe, sr_wr_o pulses for one cycle. sr_o then carries the captured status register with bit 13 (supervisor) set and bits 15 and 14 (trace controls) cleared. All other bits are unchanged.
- R3: The status-register word written to the stack is the value sampled with the strobe, before any forcing.
- R4: The frame consists of exactly four word writes at descending addresses, each 2 below the previous one. The first write is at ssp-2 and carries the format/offset word. Then come PC bits [15:0] at ssp-4, PC bits [31:16] at ssp-6 and the saved status register at ssp-8. Each request holds its address and data until wr_ack_i.
- R5: The format/offset word is 16'h0020: format 0 in bits [15:12] and vector offset 8*4 in bits [11:0].
- R6: The stacked program counter equals viol_pc_i sampled with the strobe, which is the address of the faulting instruction's first word.
- R7: Once the frame is complete, ssp_o equals the sampled stack pointer minus 8 (modulo 2^32), and it holds that value while idle.
- R8: After the last frame write, a single vector read is requested at vbr_i + 32'h20 and held until rd_ack_i.
- R9: One cycle after rd_ack_i, resume_valid_o pulses for one cycle with resume_addr_o equal to the rd_data_i returned with the acknowledge.
- R10: busy_o rises in the cycle after an accepted strobe and stays high up to and including the resume_valid_o cycle. A strobe seen while busy_o is high starts nothing: it causes no further writes, reads or resume pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_i | input | 1 | Privilege violation strobe |
| viol_pc_i | input | 32 | Address of the faulting instruction's first word |
| sr_i | input | 16 | Live status register |
| ssp_i | input | 32 | Supervisor stack pointer |
| vbr_i | input | 32 | Vector table base |
| busy_o | output | 1 | Sequence in progress |
| sr_wr_o | output | 1 | Load strobe for the forced status register |
| sr_o | output | 16 | Forced status register value |
| wr_req_o | output | 1 | Stack word write request |
| wr_addr_o | output | 32 | Stack write byte address |
| wr_data_o | output | 16 | Stack write data word |
| wr_ack_i | input | 1 | Stack write acknowledge |
| ssp_o | output | 32 | Updated supervisor stack pointer |
| rd_req_o | output | 1 | Vector read request |
| rd_addr_o | output | 32 | Vector entry address |
| rd_ack_i | input | 1 | Vector read acknowledge, data valid |
| rd_data_i | input | 32 | Vector entry contents |
| resume_valid_o | output | 1 | Resume address valid pulse |
| resume_addr_o | output | 32 | Handler address to prefetch from |

## Verification
The properties assume that wr_ack_i and rd_ack_i are high only in cycles where the matching request is high. They also assume that each acknowledge lasts a single cycle. The bench's memory responder keeps to this: it sees the request at a falling edge, raises the acknowledge for exactly one cycle after an optional number of wait cycles, and then drops it. Violation strobes are one cycle wide. Strobes that overlap a sequence are deliberate, and they test that the block drops them.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_PUSH,
        ST_VECFETCH,
        ST_DONE
    } trap_state_e;

    // Position of each word in the push sequence (first written = highest address)
    localparam logic [1:0] SLOT_FMT   = 2'd0;
    localparam logic [1:0] SLOT_PC_LO = 2'd1;
    localparam logic [1:0] SLOT_PC_HI = 2'd2;
    localparam logic [1:0] SLOT_SR    = 2'd3;

endpackage

// File: rtl/priv_sr_force.sv
module priv_sr_force #(
    parameter int SR_W   = 16,
    parameter int S_BIT  = 13,
    parameter int T1_BIT = 15,
    parameter int T0_BIT = 14
) (
    input  logic [SR_W-1:0] sr_in,
    output logic [SR_W-1:0] sr_out
);
    // Set the supervisor bit, clear both trace controls, pass everything else
    for (genvar b = 0; b < SR_W; b++) begin : g_bit
        if (b == S_BIT) begin : g_set
            assign sr_out[b] = 1'b1;
        end else if (b == T1_BIT || b == T0_BIT) begin : g_clr
            assign sr_out[b] = 1'b0;
        end else begin : g_pass
            assign sr_out[b] = sr_in[b];
        end
    end
endmodule

// File: rtl/priv_frame_word.sv
module priv_frame_word
    import priv_trap_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SR_W    = 16,
    parameter int VEC_NUM = 8,
    parameter int FMT_W   = 4
) (
    input  logic [1:0]          slot,
    input  logic [2*WORD_W-1:0] pc,
    input  logic [SR_W-1:0]     sr_saved,
    output logic [WORD_W-1:0]   word
);
    localparam int OFF_W = WORD_W - FMT_W;
    localparam logic [OFF_W-1:0] VEC_OFF = OFF_W'(VEC_NUM * 4);

    always_comb begin
        unique case (slot)
            SLOT_FMT:   word = {{FMT_W{1'b0}}, VEC_OFF};
            SLOT_PC_LO: word = pc[WORD_W-1:0];
            SLOT_PC_HI: word = pc[2*WORD_W-1:WORD_W];
            default:    word = WORD_W'(sr_saved);
        endcase
    end
endmodule

// File: rtl/priv_trap_seq.sv
module priv_trap_seq
    import priv_trap_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SR_W    = 16,
    parameter int VEC_NUM = 8,
    parameter int S_BIT   = 13,
    parameter int T1_BIT  = 15,
    parameter int T0_BIT  = 14,
    localparam int ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_i,
    input  logic [ADDR_W-1:0] viol_pc_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic [ADDR_W-1:0] ssp_i,
    input  logic [ADDR_W-1:0] vbr_i,
    output logic              busy_o,
    output logic              sr_wr_o,
    output logic [SR_W-1:0]   sr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic [ADDR_W-1:0] ssp_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic              resume_valid_o,
    output logic [ADDR_W-1:0] resume_addr_o
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] VEC_OFFSET = ADDR_W'(VEC_NUM) << 2;

    typedef struct packed {
        trap_state_e       st;
        logic [1:0]        slot;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] vbr;
        logic [ADDR_W-1:0] res;
        logic [SR_W-1:0]   sr_copy;
    } seq_t;

    seq_t s_d, s_q;
    logic [WORD_W-1:0] frame_word;
    logic [SR_W-1:0]   sr_forced;

    priv_sr_force #(
        .SR_W(SR_W), .S_BIT(S_BIT), .T1_BIT(T1_BIT), .T0_BIT(T0_BIT)
    ) u_force (
        .sr_in (s_q.sr_copy),
        .sr_out(sr_forced)
    );

    priv_frame_word #(
        .WORD_W(WORD_W), .SR_W(SR_W), .VEC_NUM(VEC_NUM)
    ) u_frame (
        .slot    (s_q.slot),
        .pc      (s_q.pc),
        .sr_saved(s_q.sr_copy),
        .word    (frame_word)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (viol_i) begin
                    s_d.st      = ST_SAVE;
                    s_d.pc      = viol_pc_i;
                    s_d.sr_copy = sr_i;
                    s_d.sp      = ssp_i;
                    s_d.vbr     = vbr_i;
                    s_d.slot    = SLOT_FMT;
                end
            end
            ST_SAVE: s_d.st = ST_PUSH;
            ST_PUSH: begin
                if (wr_ack_i) begin
                    s_d.sp   = s_q.sp - STEP;
                    s_d.slot = s_q.slot + 2'd1;
                    if (s_q.slot == SLOT_SR) s_d.st = ST_VECFETCH;
                end
            end
            ST_VECFETCH: begin
                if (rd_ack_i) begin
                    s_d.res = rd_data_i;
                    s_d.st  = ST_DONE;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, slot: '0, pc: '0, sp: '0, vbr: '0, res: '0, sr_copy: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o         = (s_q.st != ST_IDLE);
    assign sr_wr_o        = (s_q.st == ST_SAVE);
    assign sr_o           = sr_forced;
    assign wr_req_o       = (s_q.st == ST_PUSH);
    assign wr_addr_o      = s_q.sp - STEP;
    assign wr_data_o      = frame_word;
    assign ssp_o          = s_q.sp;
    assign rd_req_o       = (s_q.st == ST_VECFETCH);
    assign rd_addr_o      = s_q.vbr + VEC_OFFSET;
    assign resume_valid_o = (s_q.st == ST_DONE);
    assign resume_addr_o  = s_q.res;

endmodule

// File: rtl/priv_trap_seq_chk.sv
module priv_trap_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 16,
    parameter int SR_W   = 16,
    parameter int S_BIT  = 13,
    parameter int T1_BIT = 15,
    parameter int T0_BIT = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              viol_i,
    input logic              busy_o,
    input logic              sr_wr_o,
    input logic [SR_W-1:0]   sr_o,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [WORD_W-1:0] wr_data_o,
    input logic              wr_ack_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              resume_valid_o
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wr_req_o && !rd_req_o && !resume_valid_o && !sr_wr_o));

    assert_sr_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_o |-> (sr_o[S_BIT] && !sr_o[T1_BIT] && !sr_o[T0_BIT]));

    assert_sr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_o |=> !sr_wr_o);

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    assert_one_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req_o && rd_req_o));

    assert_rd_to_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> resume_valid_o);

    assert_resume_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |=> !resume_valid_o);

    assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_i && !busy_o) |=> (busy_o && sr_wr_o));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !resume_valid_o) |=> busy_o);
endmodule

bind priv_trap_seq priv_trap_seq_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SR_W(SR_W),
    .S_BIT(S_BIT), .T1_BIT(T1_BIT), .T0_BIT(T0_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .viol_i(viol_i), .busy_o(busy_o),
    .sr_wr_o(sr_wr_o), .sr_o(sr_o), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .resume_valid_o(resume_valid_o)
);

// File: tb/priv_trap_seq_bench.sv
module priv_trap_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        viol_i = 1'b0;
    logic [31:0] viol_pc_i = '0;
    logic [15:0] sr_i = '0;
    logic [31:0] ssp_i = '0;
    logic [31:0] vbr_i = '0;
    logic        busy_o, sr_wr_o, wr_req_o, rd_req_o, resume_valid_o;
    logic [15:0] sr_o, wr_data_o;
    logic [31:0] wr_addr_o, ssp_o, rd_addr_o, resume_addr_o;
    logic        wr_ack_i = 1'b0;
    logic        rd_ack_i = 1'b0;
    logic [31:0] rd_data_i = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Logs filled by the responder/monitor
    int          n_wr = 0;
    logic [31:0] wa [0:7];
    logic [15:0] wd [0:7];
    int          n_rd = 0;
    logic [31:0] ra;
    int          n_sr = 0;
    logic [15:0] sr_seen;
    int          n_res = 0;
    logic [31:0] res_seen;
    int          ack_wait = 0;
    int          wcnt = 0;

    localparam logic [31:0] VT_MASK = 32'hA5A5_0000;

    always #10 clk = ~clk;

    priv_trap_seq u_priv_trap_seq (
        .clk(clk), .rst_n(rst_n), .viol_i(viol_i), .viol_pc_i(viol_pc_i),
        .sr_i(sr_i), .ssp_i(ssp_i), .vbr_i(vbr_i), .busy_o(busy_o),
        .sr_wr_o(sr_wr_o), .sr_o(sr_o), .wr_req_o(wr_req_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .ssp_o(ssp_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .resume_valid_o(resume_valid_o), .resume_addr_o(resume_addr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder and monitor, evaluated away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (sr_wr_o) begin n_sr++; sr_seen = sr_o; end
            if (resume_valid_o) begin n_res++; res_seen = resume_addr_o; end
            if (wr_req_o && !wr_ack_i) begin
                if (wcnt >= ack_wait) begin
                    if (n_wr < 8) begin wa[n_wr] = wr_addr_o; wd[n_wr] = wr_data_o; end
                    n_wr++;
                    wr_ack_i = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else begin
                wr_ack_i = 1'b0;
            end
            if (rd_req_o && !rd_ack_i) begin
                n_rd++;
                ra = rd_addr_o;
                rd_data_i = rd_addr_o ^ VT_MASK;
                rd_ack_i = 1'b1;
            end else begin
                rd_ack_i = 1'b0;
            end
        end
    end

    task automatic reset_test();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: everything quiet under and after reset
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 wr_req", 32'(wr_req_o), 32'd0);
        check("R1 rd_req", 32'(rd_req_o), 32'd0);
        check("R1 resume", 32'(resume_valid_o), 32'd0);
        check("R1 sr_wr", 32'(sr_wr_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", 32'(busy_o), 32'd0);
    endtask

    task automatic run_trap(input logic [31:0] pc, input logic [15:0] sr,
                            input logic [31:0] sp, input logic [31:0] vbr,
                            input int wait_cyc, input bit dup);
        logic [15:0] exp_sr;
        logic [31:0] exp_vec;
        int guard;
        n_wr = 0; n_rd = 0; n_sr = 0; n_res = 0; ack_wait = wait_cyc;
        exp_sr  = (sr | 16'h2000) & 16'h3FFF;
        exp_vec = vbr + 32'h20;
        @(negedge clk);
        viol_pc_i = pc; sr_i = sr; ssp_i = sp; vbr_i = vbr; viol_i = 1'b1;
        @(negedge clk);
        viol_i = 1'b0;
        // change inputs: the block must use its sampled values
        viol_pc_i = ~pc; sr_i = ~sr; ssp_i = sp + 32'h100; vbr_i = ~vbr;
        check("R10 busy after strobe", 32'(busy_o), 32'd1);
        check("R2 sr_wr one cycle after strobe", 32'(sr_wr_o), 32'd1);
        if (dup) begin
            // R10: strobes while busy are dropped
            viol_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            viol_i = 1'b0;
        end
        guard = 0;
        while (n_res == 0 && guard < 200) begin
            @(negedge clk);
            guard++;
            if (n_res == 0) check("R10 busy until resume", 32'(busy_o), 32'd1);
        end
        repeat (6) @(negedge clk);
        check("R10 idle after resume", 32'(busy_o), 32'd0);
        check("R2 sr pulse count", 32'(n_sr), 32'd1);
        check("R2 forced sr", 32'(sr_seen), 32'(exp_sr));
        check("R4 write count", 32'(n_wr), 32'd4);
        check("R4 addr fmt", wa[0], sp - 32'd2);
        check("R5 fmt word", 32'(wd[0]), 32'h0020);
        check("R4 addr pc lo", wa[1], sp - 32'd4);
        check("R6 pc lo", 32'(wd[1]), 32'(pc[15:0]));
        check("R4 addr pc hi", wa[2], sp - 32'd6);
        check("R6 pc hi", 32'(wd[2]), 32'(pc[31:16]));
        check("R4 addr sr", wa[3], sp - 32'd8);
        check("R3 saved sr", 32'(wd[3]), 32'(sr));
        check("R7 final ssp", ssp_o, sp - 32'd8);
        check("R8 read count", 32'(n_rd), 32'd1);
        check("R8 vector addr", ra, exp_vec);
        check("R9 resume count", 32'(n_res), 32'd1);
        check("R9 resume addr", res_seen, exp_vec ^ VT_MASK);
    endtask

    initial begin
        reset_test();
        run_trap(32'h0040_1236, 16'hC71F, 32'h0000_8000, 32'h0000_0000, 0, 1'b0);
        run_trap(32'hFFFF_FFFE, 16'h4000, 32'h0000_0010, 32'h1000_0000, 2, 1'b0);
        run_trap(32'h1234_5678, 16'h0000, 32'h0000_0004, 32'h0000_0400, 1, 1'b1);
        run_trap(32'h8000_0002, 16'hFFFF, 32'h0200_0000, 32'hFFFF_FFF0, 3, 1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule